// File: doc/BRIEF.md
# Alternating-Turn Obstacle Steering Controller

This block is a small synchronous Mealy controller for a vehicle that drives in a straight line. A single sensor bit reports whether the way ahead is blocked. While the path is blocked the controller issues a turn command. Each new blockage is handled with the opposite turn direction from the previous one, so the block keeps a record of which way it last turned and whether a turn is in progress.

The record is held in a two-bit state register with a fixed Gray-style code, so every legal transition flips exactly one bit. The turn command is combinational from the present state and the sensor bit. A synchronous, active-high clear puts the controller back in the "path clear, last turn was left" state. The first blockage after a clear is therefore handled with a right turn. A parameter selects how the command decoder is built: either from reduced equations or from a per-state case table. Both variants behave the same at the ports.

Top module: `alt_steer_ctrl`

## Requirements
- R1: When `clr_i` is high at a rising edge, the controller enters the clear-path/last-left state (code 00). The next blockage then gives a right-turn command `steer_o = 01`.
- R2: In either clear-path state (code 00 or 11) with `blocked_i = 0`, `steer_o` is 00 and the state is unchanged.
- R3: In state 00 with `blocked_i = 1`, `steer_o` is 01 (turn right) in the same cycle, and the next state is turning-right (code 01).
- R4: In state 01 with `blocked_i = 1`, `steer_o` stays 01 and the state is unchanged.
- R5: In state 01 with `blocked_i = 0`, `steer_o` is 00 and the next state is clear-path/last-right (code 11).
- R6: In state 11 with `blocked_i = 1`, `steer_o` is 10 (turn left) in the same cycle, and the next state is turning-left (code 10).
- R7: In state 10, `blocked_i = 1` keeps `steer_o = 10` and holds the state. `blocked_i = 0` gives `steer_o = 00` and the next state is 00.
- R8: `steer_o` is never 11, and it is 00 in every cycle where `blocked_i = 0`.
- R9: When `clr_i` and `blocked_i` are high in the same cycle, `steer_o` in that cycle still follows the current state. The clear still wins for the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| clr_i | input | 1 | Synchronous clear, active high |
| blocked_i | input | 1 | 1 = obstacle ahead, 0 = path clear |
| steer_o | output | CMD_W (2) | Turn command: 00 none, 01 right, 10 left |

## Verification
The clear and an active blockage can land in the same cycle. In that cycle the combinational command must reflect the current state, while the clear decides the next state. The bench provokes this by asserting `clr_i` while `blocked_i` is held high in the middle of a left turn, and again in the middle of a right turn. The command in the clear cycle is compared with the model's turn for the old state. The cycle after that must show a right turn when the blockage is still present.

// File: rtl/alt_steer_pkg.sv
package alt_steer_pkg;
   localparam int unsigned NAV_STATE_W = 2;
   localparam int unsigned NAV_CMD_W   = 2;

   typedef enum logic [NAV_STATE_W-1:0] {
      NAV_HOME_LEFT  = 2'b00,
      NAV_TURN_RIGHT = 2'b01,
      NAV_HOME_RIGHT = 2'b11,
      NAV_TURN_LEFT  = 2'b10
   } nav_state_e;

   localparam logic [NAV_CMD_W-1:0] CMD_NONE  = 2'b00;
   localparam logic [NAV_CMD_W-1:0] CMD_RIGHT = 2'b01;
   localparam logic [NAV_CMD_W-1:0] CMD_LEFT  = 2'b10;

   localparam int unsigned DEC_EQUATIONS = 0;
   localparam int unsigned DEC_TABLE     = 1;
endpackage

// File: rtl/alt_steer_state_reg.sv
module alt_steer_state_reg #(
   parameter int unsigned           WIDTH   = 2,
   parameter logic [WIDTH-1:0]      CLR_VAL = '0
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH == 0) begin : g_bad_width
      $error("alt_steer_state_reg: WIDTH must be nonzero");
   end

   always_ff @(posedge clk_i) begin
      if (clr_i) q_o <= CLR_VAL;
      else       q_o <= d_i;
   end
endmodule

// File: rtl/alt_steer_next.sv
module alt_steer_next
   import alt_steer_pkg::*;
#(
   parameter int unsigned STATE_W = NAV_STATE_W
) (
   input  logic [STATE_W-1:0] cur_i,
   input  logic               blocked_i,
   output logic [STATE_W-1:0] nxt_o
);
   if (STATE_W != NAV_STATE_W) begin : g_bad_state_w
      $error("alt_steer_next: STATE_W must equal the package state width");
   end

   nav_state_e cur_s;
   nav_state_e nxt_s;

   assign cur_s = nav_state_e'(cur_i);

   always_comb begin
      nxt_s = cur_s;
      unique case (cur_s)
         NAV_HOME_LEFT:  nxt_s = blocked_i ? NAV_TURN_RIGHT : NAV_HOME_LEFT;
         NAV_TURN_RIGHT: nxt_s = blocked_i ? NAV_TURN_RIGHT : NAV_HOME_RIGHT;
         NAV_HOME_RIGHT: nxt_s = blocked_i ? NAV_TURN_LEFT  : NAV_HOME_RIGHT;
         NAV_TURN_LEFT:  nxt_s = blocked_i ? NAV_TURN_LEFT  : NAV_HOME_LEFT;
         default:        nxt_s = NAV_HOME_LEFT;
      endcase
   end

   assign nxt_o = nxt_s;
endmodule

// File: rtl/alt_steer_cmd.sv
module alt_steer_cmd
   import alt_steer_pkg::*;
#(
   parameter int unsigned STATE_W   = NAV_STATE_W,
   parameter int unsigned CMD_W     = NAV_CMD_W,
   parameter int unsigned DEC_STYLE = DEC_EQUATIONS
) (
   input  logic [STATE_W-1:0] cur_i,
   input  logic               blocked_i,
   output logic [CMD_W-1:0]   cmd_o
);
   localparam int unsigned DIR_BIT = STATE_W - 1;

   if (CMD_W != NAV_CMD_W) begin : g_bad_cmd_w
      $error("alt_steer_cmd: CMD_W must equal the package command width");
   end
   if (DEC_STYLE > DEC_TABLE) begin : g_bad_style
      $error("alt_steer_cmd: unknown DEC_STYLE");
   end

   if (DEC_STYLE == DEC_EQUATIONS) begin : g_equations
      // Upper state bit alone tells which way the present or next turn goes.
      assign cmd_o = {blocked_i & cur_i[DIR_BIT], blocked_i & ~cur_i[DIR_BIT]};
   end else begin : g_table
      always_comb begin
         cmd_o = CMD_NONE;
         if (blocked_i) begin
            unique case (nav_state_e'(cur_i))
               NAV_HOME_LEFT,  NAV_TURN_RIGHT: cmd_o = CMD_RIGHT;
               NAV_HOME_RIGHT, NAV_TURN_LEFT:  cmd_o = CMD_LEFT;
               default:                        cmd_o = CMD_NONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/alt_steer_ctrl.sv
module alt_steer_ctrl
   import alt_steer_pkg::*;
#(
   parameter int unsigned STATE_W   = NAV_STATE_W,
   parameter int unsigned CMD_W     = NAV_CMD_W,
   parameter int unsigned DEC_STYLE = DEC_EQUATIONS
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             blocked_i,
   output logic [CMD_W-1:0] steer_o
);
   localparam logic [STATE_W-1:0] HOME_CODE = STATE_W'(NAV_HOME_LEFT);

   if (STATE_W != NAV_STATE_W) begin : g_bad_state_w
      $error("alt_steer_ctrl: STATE_W must be 2");
   end

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;

   alt_steer_state_reg #(
      .WIDTH   (STATE_W),
      .CLR_VAL (HOME_CODE)
   ) u_state (
      .clk_i (clk_i),
      .clr_i (clr_i),
      .d_i   (state_d),
      .q_o   (state_q)
   );

   alt_steer_next #(
      .STATE_W (STATE_W)
   ) u_next (
      .cur_i     (state_q),
      .blocked_i (blocked_i),
      .nxt_o     (state_d)
   );

   alt_steer_cmd #(
      .STATE_W   (STATE_W),
      .CMD_W     (CMD_W),
      .DEC_STYLE (DEC_STYLE)
   ) u_cmd (
      .cur_i     (state_q),
      .blocked_i (blocked_i),
      .cmd_o     (steer_o)
   );
endmodule

// File: rtl/alt_steer_ctrl_chk.sv
module alt_steer_ctrl_chk #(
   parameter int unsigned STATE_W = 2,
   parameter int unsigned CMD_W   = 2
) (
   input logic               clk_i,
   input logic               clr_i,
   input logic               blocked_i,
   input logic [CMD_W-1:0]   steer_o,
   input logic [STATE_W-1:0] state_q
);
   logic armed_q = 1'b0;
   always_ff @(posedge clk_i) if (clr_i) armed_q <= 1'b1;

   a_r1_clear_home: assert property (@(posedge clk_i) disable iff (!armed_q)
      clr_i |=> state_q == 2'b00);
   a_r2_home_quiet: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_i && !blocked_i && (state_q == 2'b00 || state_q == 2'b11)) |=> $stable(state_q));
   a_r3_right_start: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_i && blocked_i && state_q == 2'b00) |=> state_q == 2'b01);
   a_r4_right_hold: assert property (@(posedge clk_i) disable iff (!armed_q)
      (blocked_i && state_q == 2'b01) |-> steer_o == 2'b01);
   a_r5_right_done: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_i && !blocked_i && state_q == 2'b01) |=> state_q == 2'b11);
   a_r6_left_start: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_i && blocked_i && state_q == 2'b11) |=> state_q == 2'b10);
   a_r7_left_done: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_i && !blocked_i && state_q == 2'b10) |=> state_q == 2'b00);
   a_r8_no_spare_code: assert property (@(posedge clk_i) disable iff (!armed_q)
      steer_o != 2'b11);
   a_r8_quiet_when_clear: assert property (@(posedge clk_i) disable iff (!armed_q)
      !blocked_i |-> steer_o == 2'b00);
   a_r9_single_bit_step: assert property (@(posedge clk_i) disable iff (!armed_q)
      !clr_i |=> $countones(state_q ^ $past(state_q)) <= 1);
endmodule

bind alt_steer_ctrl alt_steer_ctrl_chk #(
   .STATE_W (STATE_W),
   .CMD_W   (CMD_W)
) u_chk (
   .clk_i     (clk_i),
   .clr_i     (clr_i),
   .blocked_i (blocked_i),
   .steer_o   (steer_o),
   .state_q   (state_q)
);

// File: tb/alt_steer_ctrl_bench.sv
module alt_steer_ctrl_bench;
   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       blocked = 1'b0;
   logic [1:0] steer;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural model: last direction taken and whether a turn is under way
   bit last_right = 1'b0;
   bit turning    = 1'b0;

   always #10 clk = ~clk;

   alt_steer_ctrl u_alt_steer_ctrl (
      .clk_i     (clk),
      .clr_i     (clr),
      .blocked_i (blocked),
      .steer_o   (steer)
   );

   function automatic logic [1:0] model_cmd(input bit blk);
      bit go_right;
      if (!blk) return 2'b00;
      go_right = turning ? last_right : !last_right;
      return go_right ? 2'b01 : 2'b10;
   endfunction

   function automatic string tag_of(input bit c, input bit blk);
      if (c) return "R9";
      if (!blk) begin
         if (!turning) return "R2";
         return last_right ? "R5" : "R7";
      end
      if (turning) return last_right ? "R4" : "R7";
      return last_right ? "R6" : "R3";
   endfunction

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: steer=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive, compare mid-cycle, advance model at the edge
   task automatic step(input bit c, input bit blk);
      @(negedge clk);
      clr = c;
      blocked = blk;
      #5;
      check(tag_of(c, blk), steer, model_cmd(blk));
      if (!blk) check("R8", steer, 2'b00);
      else check("R8", {1'b0, steer == 2'b11}, 2'b00);
      @(posedge clk);
      if (c) begin
         last_right = 1'b0;
         turning = 1'b0;
      end else if (blk) begin
         if (!turning) last_right = !last_right;
         turning = 1'b1;
      end else begin
         turning = 1'b0;
      end
   endtask

   task automatic burst(input int n, input bit blk);
      for (int i = 0; i < n; i++) step(1'b0, blk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      int lfsr;
      // initial clear; model starts at home-left
      @(negedge clk); clr = 1'b1; blocked = 1'b0;
      @(posedge clk); @(negedge clk);
      clr = 1'b0; blocked = 1'b1; #5;
      check("R1", steer, 2'b01);       // first blockage after clear: right
      clr = 1'b1; blocked = 1'b0;
      @(posedge clk);
      last_right = 1'b0; turning = 1'b0;

      burst(3, 1'b0);                   // R2 idle at home-left
      burst(3, 1'b1);                   // R3 then R4
      burst(2, 1'b0);                   // R5 then R2 at home-right
      burst(4, 1'b1);                   // R6 then R7 hold
      burst(1, 1'b0);                   // R7 back to home-left
      burst(1, 1'b1); burst(1, 1'b0);   // single-cycle right
      burst(1, 1'b1); burst(1, 1'b0);   // single-cycle left
      burst(1, 1'b1);                   // right again

      // R9: clear with obstacle, mid right turn, then mid left turn
      step(1'b1, 1'b1);
      burst(2, 1'b1);                   // must be a fresh right turn
      burst(1, 1'b0);
      burst(2, 1'b1);                   // left turn
      step(1'b1, 1'b1);                 // clear mid left
      burst(1, 1'b1);                   // right after clear (R1)
      step(1'b1, 1'b0);                 // plain clear
      burst(1, 1'b1);

      lfsr = 32'h1d2c3b4a;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[7:0] == 8'h00, lfsr[3] ^ lfsr[9]);
      end
      finish_run();
   end
endmodule